// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block is a bus master. It takes byte and word read or write requests from on-chip logic and runs them as cycles on an external bus. On that bus, address and data share sixteen lines, and eight further lines carry the upper address bits. Each cycle starts with an address phase, marked by an address-latch strobe that an external latch uses to capture the low address bits. A read or write strobe phase follows, and each cycle ends with one recovery clock in which all strobes are inactive.

The address space falls into three areas: an I/O window at the bottom of the map, a lower external area and an upper external area. Each area has its own bus width (8 or 16 bits) and its own count of 0 to 3 wait clocks. The block splits a word access into two ordered byte cycles when the area's bus is 8 bits wide or when the address is odd on a 16-bit bus. An optional ready input can stretch the strobe phase. A select vector decides, line by line, whether each upper line carries the held address or a general-purpose output value.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset, and whenever no cycle is in its address or strobe phase, ad_oe_o is 0, ale_o is 0, and rd_n_o, wrl_n_o and wrh_n_o are all 1 (inactive).
- R2: The upper address latch resets to 0. It changes only at the start of an address phase, and it holds the last cycle's bits [23:16] while the bus is idle.
- R3: On a 16-bit area, a byte access to an even address uses lane ad[7:0] with wrl_n_o, and a byte access to an odd address uses lane ad[15:8] with wrh_n_o. A read asserts rd_n_o and returns the byte on the same lane in rsp_rdata_o[7:0].
- R4: On a 16-bit area, a word access to an even address is one cycle. A write asserts wrl_n_o and wrh_n_o together, with the low byte on ad[7:0] and the high byte on ad[15:8]. A read returns both lanes.
- R5: On a 16-bit area, a word access to an odd address A is two cycles. Cycle 1 uses address A, with the low byte on ad[15:8] and wrh_n_o. Cycle 2 uses A+1 (the carry reaches the upper lines), with the high byte on ad[7:0] and wrl_n_o.
- R6: On an 8-bit area, every transfer uses ad[7:0] and wrl_n_o only. A word access is two cycles: the low byte at A, then the high byte at A+1, for any alignment.
- R7: The area is decoded from the request address. It is the I/O area when bits [23:8] are all zero, the upper area when bit 23 is 1, and the lower area otherwise. Wait counts come from cfg_wait_i[7:6] (I/O), [5:4] (upper) and [1:0] (lower). cfg_width8_i bit 0 (I/O), bit 1 (lower) and bit 2 (upper) select an 8-bit bus when 1. The strobe phase lasts 1 + wait clocks.
- R8: Each cycle runs in this order: one clock with ale_o high, driving the address on ad_o and upper_o with ad_oe_o high; then the strobe phase; then one recovery clock before any later address phase.
- R9: When cfg_rdy_en_i is 1 and rdy_i is sampled 0 in the last strobe clock, the strobe phase is extended until rdy_i is sampled 1. When cfg_rdy_en_i is 0, rdy_i has no effect.
- R10: req_ready_o is 1 only while the block is idle. A request is accepted on a clock with req_valid_i and req_ready_o both high. rsp_done_o pulses for exactly one clock, the recovery clock after the final strobe phase, with the read data on rsp_rdata_o (upper byte 0 for byte reads).
- R11: When bit n of cfg_gpio_sel_i is 1, upper_o[n] follows gpio_out_i[n]. When it is 0, upper_o[n] carries the held address bit 16+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wait_i | input | 8 | Wait counts per area |
| cfg_width8_i | input | 3 | 8-bit bus select per area |
| cfg_rdy_en_i | input | 1 | Enables the ready input |
| cfg_gpio_sel_i | input | 8 | Upper line is general output when 1 |
| gpio_out_i | input | 8 | General output values for the upper lines |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_addr_i | input | 24 | Byte address |
| req_word_i | input | 1 | 1 = word, 0 = byte |
| req_write_i | input | 1 | 1 = write |
| req_wdata_i | input | 16 | Write data, low byte in [7:0] |
| rsp_done_o | output | 1 | Access complete pulse |
| rsp_rdata_o | output | 16 | Read data |
| ad_o | output | 16 | Address/data bus output value |
| ad_oe_o | output | 1 | Bus output enable |
| ad_i | input | 16 | Address/data bus input value |
| upper_o | output | 8 | Upper address or general output lines |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wrl_n_o | output | 1 | Low-lane write strobe, active low |
| wrh_n_o | output | 1 | High-lane write strobe, active low |
| rdy_i | input | 1 | External ready |

## Verification
Byte accesses go to even and odd addresses on a 16-bit area, so a swapped lane or strobe shows up at once. Word accesses run at even and odd addresses on both bus widths. One of them straddles a 64 KiB boundary, which separates the one-cycle case from the split cases and checks both the byte order and the carry into the upper lines. The emulated bus returns a different value on each lane and for each latched address, so a read that takes the wrong lane or merges the wrong bytes gives a wrong result. The tests also vary the area and its wait count, hold ready low with the input enabled and with it disabled, and set the general-output select while the bus is idle. These show that strobe length and the upper lines depend only on their own controls.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_STRB, ST_RCOV} bus_state_e;

  typedef struct packed {
    logic two_beats;   // access split into two byte cycles
    logic both_lanes;  // full 16-bit transfer in one cycle
    logic lane_hi;     // byte travels on ad[15:8]
    logic byte_hi;     // this beat carries the high data byte
  } beat_plan_t;
endpackage

// File: rtl/mbc_area_dec.sv
module mbc_area_dec #(
  parameter int unsigned AW           = 24,
  parameter int unsigned IO_SPAN_BITS = 8,
  parameter int unsigned WS_W         = 2
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [4*WS_W-1:0] cfg_wait_i,
  input  logic [2:0]        cfg_width8_i,
  output logic [WS_W-1:0]   wait_o,
  output logic              width8_o
);
  logic is_io, is_hi;

  always_comb begin
    is_io = (addr_i[AW-1:IO_SPAN_BITS] == '0);
    is_hi = addr_i[AW-1];
    if (is_io) begin
      wait_o   = cfg_wait_i[4*WS_W-1 -: WS_W];
      width8_o = cfg_width8_i[0];
    end else if (is_hi) begin
      wait_o   = cfg_wait_i[3*WS_W-1 -: WS_W];
      width8_o = cfg_width8_i[2];
    end else begin
      wait_o   = cfg_wait_i[WS_W-1:0];
      width8_o = cfg_width8_i[1];
    end
  end
endmodule

// File: rtl/mbc_lane_plan.sv
module mbc_lane_plan
  import mux_bus_pkg::*;
(
  input  logic        width8_i,
  input  logic        word_i,
  input  logic        a0_i,
  input  logic        beat_i,
  input  logic [15:0] wdata_i,
  output beat_plan_t  plan_o,
  output logic [15:0] bus_wdata_o
);
  logic [7:0] sel_byte;

  always_comb begin
    plan_o.two_beats  = word_i && (width8_i || a0_i);
    plan_o.both_lanes = word_i && !plan_o.two_beats;
    plan_o.lane_hi    = !width8_i && (a0_i ^ beat_i) && !plan_o.both_lanes;
    plan_o.byte_hi    = word_i && beat_i;
    sel_byte = plan_o.byte_hi ? wdata_i[15:8] : wdata_i[7:0];
    if (plan_o.both_lanes)  bus_wdata_o = wdata_i;
    else if (plan_o.lane_hi) bus_wdata_o = {sel_byte, 8'h00};
    else                     bus_wdata_o = {8'h00, sel_byte};
  end
endmodule

// File: rtl/mbc_upper_mux.sv
module mbc_upper_mux #(
  parameter int unsigned UW = 8
) (
  input  logic [UW-1:0] held_i,
  input  logic [UW-1:0] sel_i,
  input  logic [UW-1:0] gpio_i,
  output logic [UW-1:0] pins_o
);
  for (genvar n = 0; n < UW; n++) begin : g_pin
    assign pins_o[n] = sel_i[n] ? gpio_i[n] : held_i[n];
  end
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mux_bus_pkg::*;
#(
  parameter int unsigned AW           = 24,
  parameter int unsigned IO_SPAN_BITS = 8,
  parameter int unsigned WS_W         = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [4*WS_W-1:0]   cfg_wait_i,
  input  logic [2:0]          cfg_width8_i,
  input  logic                cfg_rdy_en_i,
  input  logic [AW-17:0]      cfg_gpio_sel_i,
  input  logic [AW-17:0]      gpio_out_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [AW-1:0]       req_addr_i,
  input  logic                req_word_i,
  input  logic                req_write_i,
  input  logic [15:0]         req_wdata_i,
  output logic                rsp_done_o,
  output logic [15:0]         rsp_rdata_o,
  output logic [15:0]         ad_o,
  output logic                ad_oe_o,
  input  logic [15:0]         ad_i,
  output logic [AW-17:0]      upper_o,
  output logic                ale_o,
  output logic                rd_n_o,
  output logic                wrl_n_o,
  output logic                wrh_n_o,
  input  logic                rdy_i
);
  localparam int unsigned UW = AW - 16;

  bus_state_e      state_q;
  logic [AW-1:0]   addr_q;
  logic            word_q, write_q, beat_q, w8_q, done_q;
  logic [15:0]     wdata_q, rdata_q, bus_wdata;
  logic [WS_W-1:0] ws_q, wait_cnt_q, dec_wait;
  logic            dec_w8;
  logic [UW-1:0]   upper_q;
  logic [AW-1:0]   beat_addr, next_addr;
  beat_plan_t      plan;
  logic            strb, strobe_end, last_beat;
  logic [7:0]      lane_byte;

  mbc_area_dec #(.AW(AW), .IO_SPAN_BITS(IO_SPAN_BITS), .WS_W(WS_W)) u_area (
    .addr_i(req_addr_i), .cfg_wait_i(cfg_wait_i), .cfg_width8_i(cfg_width8_i),
    .wait_o(dec_wait), .width8_o(dec_w8)
  );

  mbc_lane_plan u_plan (
    .width8_i(w8_q), .word_i(word_q), .a0_i(addr_q[0]), .beat_i(beat_q),
    .wdata_i(wdata_q), .plan_o(plan), .bus_wdata_o(bus_wdata)
  );

  mbc_upper_mux #(.UW(UW)) u_upper (
    .held_i(upper_q), .sel_i(cfg_gpio_sel_i), .gpio_i(gpio_out_i), .pins_o(upper_o)
  );

  assign beat_addr  = addr_q + AW'(beat_q);
  assign next_addr  = addr_q + AW'(1);
  assign strb       = (state_q == ST_STRB);
  assign strobe_end = strb && (wait_cnt_q == '0) && (!cfg_rdy_en_i || rdy_i);
  assign last_beat  = !plan.two_beats || beat_q;
  assign lane_byte  = plan.lane_hi ? ad_i[15:8] : ad_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      word_q     <= 1'b0;
      write_q    <= 1'b0;
      wdata_q    <= '0;
      beat_q     <= 1'b0;
      w8_q       <= 1'b0;
      ws_q       <= '0;
      wait_cnt_q <= '0;
      rdata_q    <= '0;
      upper_q    <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= strobe_end && last_beat;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          word_q  <= req_word_i;
          write_q <= req_write_i;
          wdata_q <= req_wdata_i;
          ws_q    <= dec_wait;
          w8_q    <= dec_w8;
          beat_q  <= 1'b0;
          rdata_q <= '0;
          upper_q <= req_addr_i[AW-1:16];
          state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          wait_cnt_q <= ws_q;
          state_q    <= ST_STRB;
        end
        ST_STRB: begin
          if (wait_cnt_q != '0) wait_cnt_q <= wait_cnt_q - 1'b1;
          else if (strobe_end) begin
            if (plan.both_lanes)   rdata_q        <= ad_i;
            else if (plan.byte_hi) rdata_q[15:8]  <= lane_byte;
            else                   rdata_q[7:0]   <= lane_byte;
            state_q <= ST_RCOV;
          end
        end
        ST_RCOV: begin
          if (!last_beat) begin
            beat_q  <= 1'b1;
            upper_q <= next_addr[AW-1:16];
            state_q <= ST_ADDR;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready_o = (state_q == ST_IDLE);
    ale_o       = (state_q == ST_ADDR);
    rd_n_o      = !(strb && !write_q);
    wrl_n_o     = !(strb && write_q && (plan.both_lanes || !plan.lane_hi));
    wrh_n_o     = !(strb && write_q && (plan.both_lanes || plan.lane_hi));
    ad_oe_o     = ale_o || (strb && write_q);
    ad_o        = ale_o ? beat_addr[15:0] : (ad_oe_o ? bus_wdata : 16'h0000);
    rsp_done_o  = done_q;
    rsp_rdata_o = rdata_q;
  end

  // Strobe-length observer, saturating
  logic       strb_act;
  logic [3:0] strb_len_q;
  assign strb_act = !rd_n_o || !wrl_n_o || !wrh_n_o;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_len_q <= '0;
    else if (strb_act) strb_len_q <= (strb_len_q == 4'hF) ? strb_len_q : strb_len_q + 1'b1;
    else strb_len_q <= '0;
  end

  assert_bus_released_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_o && !strb_act) |-> !ad_oe_o);
  assert_upper_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$rose(ale_o) && $stable(cfg_gpio_sel_i) && $stable(gpio_out_i)) |-> $stable(upper_o));
  assert_read_write_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> (wrl_n_o && wrh_n_o));
  assert_narrow_lane_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb && w8_q) |-> wrh_n_o);
  assert_strobe_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_act) |-> (strb_len_q > 4'(ws_q)));
  assert_ale_alone_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (!strb_act && ad_oe_o));
  assert_recovery_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_act) |-> !ale_o);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);
  assert_ready_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!ale_o && !strb_act));
endmodule

// File: tb/mux_bus_ctrl_tb.sv
module mux_bus_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_wait = 8'h60;
  logic [2:0]  cfg_width8 = 3'b001;
  logic        cfg_rdy_en = 1'b0;
  logic [7:0]  gpio_sel = 8'h00, gpio_out = 8'h00;
  logic        valid = 1'b0, word = 1'b0, write = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        ready, done, ad_oe, ale, rd_n, wrl_n, wrh_n, rdy;
  logic [15:0] rdata, ad_o, ad_i;
  logic [7:0]  upper;

  always #2 clk = ~clk;

  mux_bus_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wait_i(cfg_wait), .cfg_width8_i(cfg_width8),
    .cfg_rdy_en_i(cfg_rdy_en), .cfg_gpio_sel_i(gpio_sel), .gpio_out_i(gpio_out),
    .req_valid_i(valid), .req_ready_o(ready), .req_addr_i(addr), .req_word_i(word),
    .req_write_i(write), .req_wdata_i(wdata), .rsp_done_o(done), .rsp_rdata_o(rdata),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .ad_i(ad_i), .upper_o(upper), .ale_o(ale),
    .rd_n_o(rd_n), .wrl_n_o(wrl_n), .wrh_n_o(wrh_n), .rdy_i(rdy)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // Bus observer and emulated memory: each lane returns a distinct value per address
  int          nbeat = 0, ndone = 0, viol = 0, rdy_hold = 0, cur;
  logic [23:0] r_addr [4];
  int          r_len [4];
  logic [2:0]  r_strb [4];   // {rd, wrh, wrl} active high
  logic [15:0] r_data [4];
  logic [15:0] r_rdata;
  logic [23:0] lat = '0;
  bit          prev_strb = 0, strb_now;

  assign ad_i = {lat[7:0] ^ 8'hA5, lat[7:0] ^ 8'h5A};
  initial rdy = 1'b1;

  always @(negedge clk) if (rst_n) begin
    strb_now = !rd_n || !wrl_n || !wrh_n;
    if (ale) begin
      if (prev_strb || !ad_oe || strb_now) viol++;
      if (nbeat < 4) begin r_addr[nbeat] = {upper, ad_o}; r_len[nbeat] = 0; end
      lat = {upper, ad_o};
      nbeat++;
    end else if (strb_now) begin
      if (nbeat > 0 && nbeat <= 4) begin
        r_len[nbeat-1]++;
        r_strb[nbeat-1] = {!rd_n, !wrh_n, !wrl_n};
        if (!wrl_n || !wrh_n) r_data[nbeat-1] = ad_o;
      end
    end else if (ad_oe) viol++;
    if (done) begin ndone++; r_rdata = rdata; end
    prev_strb = strb_now;
    cur = (nbeat > 0 && nbeat <= 4) ? r_len[nbeat-1] : 0;
    rdy = (cur > rdy_hold);
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [23:0] a, input logic w, input logic wr, input logic [15:0] d);
    @(negedge clk);
    addr = a; word = w; write = wr; wdata = d; valid = 1'b1;
    @(posedge clk); #1;
    valid = 1'b0; nbeat = 0; ndone = 0; viol = 0;
    check("R10 ready low while busy", {31'b0, ready}, 32'd0);
    for (int i = 0; i < 300 && ndone == 0; i++) @(negedge clk);
    if (ndone == 0) check("R10 access timeout", 32'd0, 32'd1);
    @(negedge clk);
    check("R10 single done pulse", ndone, 32'd1);
    check("R10 ready after access", {31'b0, ready}, 32'd1);
    check("R8 R1 phase order and bus release", viol, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 ale idle", {31'b0, ale}, 32'd0);
    check("R1 strobes idle", {29'b0, rd_n, wrl_n, wrh_n}, 32'h7);
    check("R1 bus released", {31'b0, ad_oe}, 32'd0);
    check("R2 upper reset", {24'b0, upper}, 32'd0);
    check("R10 ready idle", {31'b0, ready}, 32'd1);
  endtask

  task automatic t_byte16;
    run(24'h012344, 0, 1, 16'h0081);
    check("R3 even byte beats", nbeat, 1);
    check("R8 even byte addr", r_addr[0], 24'h012344);
    check("R3 even byte wrl", r_strb[0], 3'b001);
    check("R3 even byte lane", r_data[0][7:0], 8'h81);
    check("R7 lower area len", r_len[0], 1);
    run(24'h012345, 0, 1, 16'h0081);
    check("R3 odd byte wrh", r_strb[0], 3'b010);
    check("R3 odd byte lane", r_data[0][15:8], 8'h81);
    run(24'h012345, 0, 0, 16'h0000);
    check("R3 odd read rd", r_strb[0], 3'b100);
    check("R3 odd read data", r_rdata, 16'h00E0);
    run(24'h012344, 0, 0, 16'h0000);
    check("R3 even read data", r_rdata, 16'h001E);
  endtask

  task automatic t_word16_even;
    run(24'h020010, 1, 1, 16'h8421);
    check("R4 beats", nbeat, 1);
    check("R4 both strobes", r_strb[0], 3'b011);
    check("R4 data", r_data[0], 16'h8421);
    run(24'h020010, 1, 0, 16'h0000);
    check("R4 read data", r_rdata, 16'hB54A);
  endtask

  task automatic t_word16_odd;
    run(24'h00FFFF, 1, 1, 16'h8421);
    check("R5 beats", nbeat, 2);
    check("R5 first addr", r_addr[0], 24'h00FFFF);
    check("R5 first wrh", r_strb[0], 3'b010);
    check("R5 first low byte on high lane", r_data[0][15:8], 8'h21);
    check("R5 R2 second addr carry", r_addr[1], 24'h010000);
    check("R5 second wrl", r_strb[1], 3'b001);
    check("R5 second high byte on low lane", r_data[1][7:0], 8'h84);
    run(24'h030011, 1, 0, 16'h0000);
    check("R5 split read data", r_rdata, 16'h48B4);
  endtask

  task automatic t_bus8;
    run(24'h000040, 1, 1, 16'h8421);
    check("R6 beats", nbeat, 2);
    check("R6 addr0", r_addr[0], 24'h000040);
    check("R6 addr1", r_addr[1], 24'h000041);
    check("R6 wrl only 0", r_strb[0], 3'b001);
    check("R6 wrl only 1", r_strb[1], 3'b001);
    check("R6 low byte first", r_data[0][7:0], 8'h21);
    check("R6 high byte second", r_data[1][7:0], 8'h84);
    check("R7 io area len", r_len[0], 2);
    run(24'h000041, 0, 1, 16'h0055);
    check("R6 odd byte strobe", r_strb[0], 3'b001);
    check("R6 odd byte lane", r_data[0][7:0], 8'h55);
    run(24'h000041, 1, 0, 16'h0000);
    check("R6 word read order", r_rdata, 16'h181B);
  endtask

  task automatic t_wait;
    run(24'h800100, 0, 1, 16'h0033);
    check("R7 upper area len ws2", r_len[0], 3);
    cfg_wait = 8'hF0;
    run(24'h800100, 0, 1, 16'h0033);
    check("R7 upper area len ws3", r_len[0], 4);
    cfg_width8 = 3'b101;
    run(24'h800100, 1, 1, 16'h8421);
    check("R7 upper 8-bit beats", nbeat, 2);
    check("R7 upper 8-bit addr1", r_addr[1], 24'h800101);
    cfg_wait = 8'h60; cfg_width8 = 3'b001;
  endtask

  task automatic t_rdy;
    cfg_rdy_en = 1'b1; rdy_hold = 3;
    run(24'h012344, 0, 0, 16'h0000);
    check("R9 stretched strobe", r_len[0], 4);
    rdy_hold = 0;
    run(24'h012344, 0, 0, 16'h0000);
    check("R9 ready high no stretch", r_len[0], 1);
    cfg_rdy_en = 1'b0; rdy_hold = 5;
    run(24'h012344, 0, 0, 16'h0000);
    check("R9 ready ignored when disabled", r_len[0], 1);
    rdy_hold = 0;
  endtask

  task automatic t_upper;
    run(24'h812345, 0, 1, 16'h0001);
    check("R8 addr phase", r_addr[0], 24'h812345);
    repeat (5) @(negedge clk);
    check("R2 upper held idle", {24'b0, upper}, 32'h81);
    gpio_sel = 8'h0F; gpio_out = 8'hA5;
    @(negedge clk);
    check("R11 low nibble gpio", {24'b0, upper}, 32'h85);
    gpio_sel = 8'hF0;
    @(negedge clk);
    check("R11 high nibble gpio", {24'b0, upper}, 32'hA1);
    gpio_sel = 8'h00;
    @(negedge clk);
    check("R11 all address", {24'b0, upper}, 32'h81);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_byte16();
    t_word16_even();
    t_word16_odd();
    t_bus8();
    t_wait();
    t_rdy();
    t_upper();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule